// File: doc/BRIEF.md
# Four-Tap Line Reorderer for Split-Readout Linear Sensors

This block receives four digitized video streams from a linear image sensor whose line is read out through four taps. Each tap carries one quarter of the line. Tap 0 carries the even-indexed pixels of the left half, and tap 1 carries the odd-indexed pixels of the left half. Taps 2 and 3 carry the even-indexed and odd-indexed pixels of the right half. The left-half taps start at the outer edge of the line and move toward the centre. The right-half taps also start at their outer edge, so that half arrives in descending pixel order. The block de-interleaves the streams, reverses the right half, and emits the rebuilt line in ascending pixel order as a plain valid/last stream.

A line begins with a one-cycle `line_start` pulse. Each tap has its own valid strobe. The taps may arrive together, one after another, or with arbitrary gaps. When every tap has delivered a quarter line, the line is handed to the readout side. The readout side streams one pixel per clock. Two line stores alternate, so the next line can be captured while the previous one drains. Samples that cannot belong to the open line raise a one-cycle overflow pulse. Restarting a line before it is complete raises a one-cycle error pulse.

Top module: `pxr_reorder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_last`, `overflow` and `line_err` are 0.
- R2: Pixel indices run from 0 to L-1, where L = `LINE_PIXELS` and L is a multiple of 4. The k-th accepted sample of a line (k from 0) maps to pixel 2k on tap 0, 2k+1 on tap 1, L-2-2k on tap 2 and L-1-2k on tap 3.
- R3: A completed line is emitted as L consecutive `out_valid` cycles carrying pixels 0, 1, …, L-1 in that order.
- R4: `out_last` is high exactly with pixel L-1 and never without `out_valid`.
- R5: A line completes on the clock edge that captures the last missing sample, with every tap then holding L/4 samples. Pixel j appears on the outputs after edge 4+j counted from that edge, provided the readout side is idle. No output for a line appears before it completes.
- R6: Any combination of the four tap valids may be high in the same cycle, and each is accepted independently.
- R7: A valid sample is dropped when no line is open or when its tap already holds L/4 samples. A dropped sample does not alter the stored line, and `overflow` pulses high on the edge that sees it.
- R8: A `line_start` while a line is open and incomplete discards the partial line and restarts all tap counts. `line_err` pulses high on that edge.
- R9: Tap samples presented in the same cycle as `line_start` are ignored: they are not stored, not counted and not flagged as overflow.
- R10: A new line may be captured while the previous line is being emitted. If it completes before the previous output ends, its output starts one idle cycle after the previous `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse opening a new line |
| tap_valid | input | 4 | Per-tap sample strobe, bit t for tap t |
| tap_data | input | 4*PIX_W | Tap t sample in bits [t*PIX_W +: PIX_W] |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | PIX_W | Output pixel value |
| out_last | output | 1 | Marks the final pixel of the line |
| overflow | output | 1 | Pulse: a sample was dropped |
| line_err | output | 1 | Pulse: an incomplete line was restarted |

## Verification
The overflow and error pulses are due on the same clock edge that samples the offending input. Output pixel j of an undelayed line is due 4+j edges after the edge that captured the completing sample. A line that had to wait is due one cycle after the previous `out_last`. The bench keeps a behavioural model on the rising edge that records each accepted sample by pixel index and schedules every finished line at the edge where its first pixel is due. On each falling edge it compares valid, data, last and both flags with the model, so an output one cycle early or late counts as a mismatch. The stimulus feeds the taps together, strictly one after another, and with random gaps. It also covers a restart that coincides with the completion cycle and a second line captured during readout.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

  localparam int NUM_TAPS = 4;

  // Tap numbering also selects the storage bank: {right half, pixel index lsb}
  typedef enum logic [1:0] {
    TAP_LEFT_EVEN  = 2'd0,
    TAP_LEFT_ODD   = 2'd1,
    TAP_RIGHT_EVEN = 2'd2,
    TAP_RIGHT_ODD  = 2'd3
  } tap_e;

  function automatic tap_e bank_for(input logic right_half, input logic idx_lsb);
    return tap_e'({right_half, idx_lsb});
  endfunction

endpackage

// File: rtl/pxr_tap_counter.sv
module pxr_tap_counter #(
  parameter int QUARTER = 6,
  parameter int IW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          open_line,
  input  logic          valid,
  output logic [IW-1:0] idx,
  output logic          accept,
  output logic          drop,
  output logic          filled
);

  assign filled = (idx == IW'(QUARTER));
  assign accept = valid && !restart && open_line && !filled;
  assign drop   = valid && !restart && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (restart) begin
      idx <= '0;
    end else if (accept) begin
      idx <= idx + IW'(1);
    end
  end

endmodule

// File: rtl/pxr_line_bank.sv
module pxr_line_bank #(
  parameter int PIX_W = 12,
  parameter int DEPTH = 6,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wr_sel,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             rd_sel,
  input  logic [IW-1:0]    rd_idx,
  output logic [PIX_W-1:0] rd_q
);

  localparam int AW = $clog2(2 * DEPTH);

  logic [PIX_W-1:0] mem [2*DEPTH];
  logic [AW-1:0]    waddr;
  logic [AW-1:0]    raddr;

  always_comb begin
    waddr = wr_sel ? AW'(DEPTH) + AW'(wr_idx) : AW'(wr_idx);
    raddr = rd_sel ? AW'(DEPTH) + AW'(rd_idx) : AW'(rd_idx);
  end

  // One write port and one registered read port per half-buffer pair
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wr_data;
    end
    rd_q <= mem[raddr];
  end

endmodule

// File: rtl/pxr_readout.sv
module pxr_readout
  import pxr_pkg::*;
#(
  parameter int LINE_PIXELS = 24,
  parameter int PW          = 5,
  parameter int IW          = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          avail,
  output logic          rd_en,
  output logic          rd_last,
  output tap_e          rd_bank,
  output logic [IW-1:0] rd_idx
);

  localparam int HALF = LINE_PIXELS / 2;

  logic          busy;
  logic [PW-1:0] ptr;
  logic          right_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (!busy) begin
      if (avail) begin
        busy <= 1'b1;
        ptr  <= '0;
      end
    end else if (rd_last) begin
      busy <= 1'b0;
    end else begin
      ptr <= ptr + PW'(1);
    end
  end

  always_comb begin
    right_half = (int'(ptr) >= HALF);
    rd_en      = busy;
    rd_last    = busy && (int'(ptr) == LINE_PIXELS - 1);
    rd_bank    = bank_for(right_half, ptr[0]);
    rd_idx     = right_half ? IW'((LINE_PIXELS - 1 - int'(ptr)) / 2)
                            : IW'(int'(ptr) / 2);
  end

endmodule

// File: rtl/pxr_reorder.sv
module pxr_reorder
  import pxr_pkg::*;
#(
  parameter int LINE_PIXELS = 48,
  parameter int PIX_W       = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        line_start,
  input  logic [NUM_TAPS-1:0]         tap_valid,
  input  logic [NUM_TAPS*PIX_W-1:0]   tap_data,
  output logic                        out_valid,
  output logic [PIX_W-1:0]            out_data,
  output logic                        out_last,
  output logic                        overflow,
  output logic                        line_err
);

  localparam int QUARTER = LINE_PIXELS / 4;
  localparam int IW      = $clog2(QUARTER + 1);
  localparam int PW      = $clog2(LINE_PIXELS);

  logic [NUM_TAPS-1:0] accept, drop, filled;
  logic [IW-1:0]       idx   [NUM_TAPS];
  logic [PIX_W-1:0]    bank_q[NUM_TAPS];

  logic       in_line, wr_sel, rd_sel;
  logic [1:0] buf_full;
  logic       complete;

  logic          rd_en, rd_last;
  tap_e          rd_bank;
  logic [IW-1:0] rd_idx;

  logic v1, last1;
  tap_e bank1;

  assign complete = in_line && (&filled);

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    pxr_tap_counter #(.QUARTER(QUARTER), .IW(IW)) u_cnt (
      .clk(clk), .rst(rst), .restart(line_start), .open_line(in_line),
      .valid(tap_valid[t]), .idx(idx[t]), .accept(accept[t]),
      .drop(drop[t]), .filled(filled[t])
    );

    pxr_line_bank #(.PIX_W(PIX_W), .DEPTH(QUARTER), .IW(IW)) u_bank (
      .clk(clk), .we(accept[t]), .wr_sel(wr_sel), .wr_idx(idx[t]),
      .wr_data(tap_data[t*PIX_W +: PIX_W]),
      .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_q(bank_q[t])
    );
  end

  pxr_readout #(.LINE_PIXELS(LINE_PIXELS), .PW(PW), .IW(IW)) u_rd (
    .clk(clk), .rst(rst), .avail(buf_full[rd_sel]),
    .rd_en(rd_en), .rd_last(rd_last), .rd_bank(rd_bank), .rd_idx(rd_idx)
  );

  // Line framing and ping-pong ownership
  always_ff @(posedge clk) begin
    if (rst) begin
      in_line  <= 1'b0;
      wr_sel   <= 1'b0;
      rd_sel   <= 1'b0;
      buf_full <= 2'b00;
      overflow <= 1'b0;
      line_err <= 1'b0;
    end else begin
      overflow <= |drop;
      line_err <= line_start && in_line && !complete;
      if (line_start) begin
        in_line <= 1'b1;
      end else if (complete) begin
        in_line <= 1'b0;
      end
      if (complete) begin
        wr_sel <= !wr_sel;
      end
      if (rd_last) begin
        rd_sel <= !rd_sel;
      end
      for (int b = 0; b < 2; b++) begin
        if (complete && (wr_sel == 1'(b))) begin
          buf_full[b] <= 1'b1;
        end else if (rd_last && (rd_sel == 1'(b))) begin
          buf_full[b] <= 1'b0;
        end
      end
    end
  end

  // Read pipeline: bank read register, then output register
  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      last1     <= 1'b0;
      bank1     <= TAP_LEFT_EVEN;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      v1        <= rd_en;
      last1     <= rd_last;
      bank1     <= rd_bank;
      out_valid <= v1;
      out_last  <= last1;
      out_data  <= v1 ? bank_q[bank1] : '0;
    end
  end

endmodule

// File: rtl/pxr_reorder_chk.sv
module pxr_reorder_chk #(
  parameter int LINE_PIXELS = 48,
  parameter int PIX_W       = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                line_start,
  input logic [3:0]          tap_valid,
  input logic                out_valid,
  input logic                out_last,
  input logic                overflow,
  input logic                line_err
);

  int beats;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats <= 0;
    end else if (out_valid) begin
      beats <= out_last ? 0 : beats + 1;
    end
  end

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R4

  AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid); // R3

  AST_LINE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (beats == LINE_PIXELS - 1)); // R3

  AST_OVF_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(|tap_valid && !line_start)); // R7

  AST_ERR_HAS_START: assert property (@(posedge clk) disable iff (rst)
    line_err |-> $past(line_start)); // R8

  AST_START_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !overflow); // R9

endmodule

bind pxr_reorder pxr_reorder_chk #(.LINE_PIXELS(LINE_PIXELS), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .tap_valid(tap_valid),
  .out_valid(out_valid), .out_last(out_last), .overflow(overflow),
  .line_err(line_err)
);

// File: tb/pxr_reorder_test.sv
module pxr_reorder_test;
  localparam int LINE = 24;
  localparam int W    = 12;
  localparam int Q    = LINE / 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           line_start = 1'b0;
  logic [3:0]     tap_valid = '0;
  logic [4*W-1:0] tap_data = '0;
  logic           out_valid, out_last, overflow, line_err;
  logic [W-1:0]   out_data;

  always #5 clk = ~clk;

  pxr_reorder #(.LINE_PIXELS(LINE), .PIX_W(W)) uut (
    .clk(clk), .rst(rst), .line_start(line_start), .tap_valid(tap_valid),
    .tap_data(tap_data), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .overflow(overflow), .line_err(line_err)
  );

  int n_run = 0, n_fail = 0, edge_no = 0;
  int lines_ok = 0, ovf_seen = 0, err_seen = 0;
  bit line_bad = 0;

  // Behavioural reference model state
  bit           m_open = 0, closing = 0, exp_ovf = 0, exp_err = 0;
  int           m_cnt [4];
  logic [W-1:0] m_pix [LINE];
  logic [W-1:0] exp_pix[$];
  int           exp_start[$];
  int           last_start = -100000;

  function automatic int tpix(int t, int k);
    case (t)
      0: return 2 * k;
      1: return 2 * k + 1;
      2: return LINE - 2 - 2 * k;
      default: return LINE - 1 - 2 * k;
    endcase
  endfunction

  function automatic logic [W-1:0] pval(int p, int lid);
    return W'((p * 7 + lid * 131 + 3) % (1 << W));
  endfunction

  function automatic bit all_full();
    return (m_cnt[0] == Q) && (m_cnt[1] == Q) && (m_cnt[2] == Q) && (m_cnt[3] == Q);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      line_bad = 1;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, edge_no);
    end
  endtask

  always @(posedge clk) begin
    edge_no++;
    if (rst) begin
      m_open = 0; exp_ovf = 0; exp_err = 0;
      for (int t = 0; t < 4; t++) m_cnt[t] = 0;
      exp_pix.delete(); exp_start.delete();
    end else begin
      closing = m_open && all_full();
      exp_ovf = 0;
      exp_err = 0;
      if (line_start) begin
        if (m_open && !closing) exp_err = 1;
        m_open = 1;
        for (int t = 0; t < 4; t++) m_cnt[t] = 0;
      end else begin
        for (int t = 0; t < 4; t++) begin
          if (tap_valid[t]) begin
            if (m_open && m_cnt[t] < Q) begin
              m_pix[tpix(t, m_cnt[t])] = tap_data[t*W +: W];
              m_cnt[t]++;
            end else begin
              exp_ovf = 1;
            end
          end
        end
        if (closing) begin
          m_open = 0;
        end else if (m_open && all_full()) begin
          int s;
          s = edge_no + 4;
          if (s < last_start + LINE + 1) s = last_start + LINE + 1;
          for (int p = 0; p < LINE; p++) exp_pix.push_back(m_pix[p]);
          exp_start.push_back(s);
          last_start = s;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit ev, el;
      logic [W-1:0] ed;
      int j;
      ev = 0; el = 0; ed = '0;
      if (exp_start.size() > 0 && edge_no >= exp_start[0]) begin
        j  = edge_no - exp_start[0];
        ev = 1;
        ed = exp_pix[j];
        el = (j == LINE - 1);
      end
      chk(out_valid == ev, "R5 out_valid", int'(out_valid), int'(ev));
      if (ev) chk(out_data == ed, "R2 R3 out_data", int'(out_data), int'(ed));
      chk(out_last == el, "R4 out_last", int'(out_last), int'(el));
      chk(overflow == exp_ovf, "R7 overflow", int'(overflow), int'(exp_ovf));
      chk(line_err == exp_err, "R8 line_err", int'(line_err), int'(exp_err));
      if (overflow) ovf_seen++;
      if (line_err) err_seen++;
      if (el) begin
        if (!line_bad) lines_ok++;
        line_bad = 0;
        for (int p = 0; p < LINE; p++) void'(exp_pix.pop_front());
        void'(exp_start.pop_front());
      end
    end
  end

  task automatic pulse_start(bit with_valid);
    @(negedge clk);
    line_start = 1;
    tap_valid  = with_valid ? 4'hF : 4'h0;
    tap_data   = '1;
    @(negedge clk);
    line_start = 0;
    tap_valid  = 0;
  endtask

  task automatic send_line(int mode, int lid, int maxcyc);
    int k[4];
    int cyc;
    int sel;
    k = '{0, 0, 0, 0};
    cyc = 0;
    while ((k[0] < Q || k[1] < Q || k[2] < Q || k[3] < Q) && cyc < maxcyc) begin
      @(negedge clk);
      line_start = 0;
      tap_valid  = 0;
      cyc++;
      sel = 0;
      while (sel < 3 && k[sel] >= Q) sel++;
      for (int t = 0; t < 4; t++) begin
        bit go;
        case (mode)
          0: go = (k[t] < Q);
          1: go = (k[t] < Q) && (t == sel);
          default: go = (k[t] < Q) && ($urandom_range(2) != 0);
        endcase
        if (go) begin
          tap_valid[t] = 1;
          tap_data[t*W +: W] = pval(tpix(t, k[t]), lid);
          k[t]++;
        end
      end
    end
  endtask

  task automatic drain();
    @(negedge clk);
    line_start = 0;
    tap_valid  = 0;
    while (exp_start.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: quiet outputs while reset is held
    chk(!out_valid && !out_last && !overflow && !line_err, "R1 reset outputs",
        int'({out_valid, out_last, overflow, line_err}), 0);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !out_last && !overflow && !line_err, "R1 after reset",
        int'({out_valid, out_last, overflow, line_err}), 0);

    // R6: all taps together every cycle
    pulse_start(0);
    send_line(0, 1, 1000);
    drain();
    chk(lines_ok == 1, "R6 simultaneous taps line", lines_ok, 1);

    // R2: strictly one tap at a time
    pulse_start(0);
    send_line(1, 2, 1000);
    drain();
    chk(lines_ok == 2, "R2 sequential taps line", lines_ok, 2);

    // R7: sample outside an open line
    @(negedge clk);
    tap_valid = 4'b0001;
    tap_data  = '1;
    // R9: samples during the start cycle are ignored
    pulse_start(1);
    send_line(2, 3, 1000);
    // R7: surplus sample on a filled tap
    @(negedge clk);
    tap_valid = 4'b0100;
    tap_data  = '1;
    drain();
    chk(lines_ok == 3, "R9 start-cycle samples ignored", lines_ok, 3);
    chk(ovf_seen == 2, "R7 overflow pulses", ovf_seen, 2);

    // R8: restart of an incomplete line
    pulse_start(0);
    send_line(0, 9, 3);
    pulse_start(0);
    send_line(0, 4, 1000);
    drain();
    chk(err_seen == 1, "R8 error pulse count", err_seen, 1);
    chk(lines_ok == 4, "R8 line after restart", lines_ok, 4);

    // R10: restart in the completion cycle, second line captured during readout
    pulse_start(0);
    send_line(0, 5, 1000);
    pulse_start(0);
    send_line(2, 6, 1000);
    drain();
    chk(lines_ok == 6, "R10 ping-pong lines", lines_ok, 6);
    chk(err_seen == 1, "R8 no error at completion restart", err_seen, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule